// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is an I2C target that holds a small bank of eight-bit configuration registers for a clock-distribution function. A host on the two-wire bus writes and reads the registers by first sending a command byte that names the starting register and picks between single-byte and block access. During a block transfer the host sends a length byte after the command on writes. On reads the target returns the contents of its byte-count register before the data. In both single and block transfers the register pointer moves up by one after each data byte.

SCL and SDA are sampled with the system clock. Start and stop conditions are taken from SDA edges while SCL is high. The target drives SDA only by pulling it low through `sda_oe`. The register bits that steer the rest of the chip come out as dedicated outputs: one reference output enable, two differential output enables, an amplitude override flag and a three-bit amplitude code.

Top module: `i2cr_ctrl`

## Requirements
- R1: The target acknowledges a transfer only when the 7-bit address is 6Bh (D6h for a write, D7h for a read). On any other address it does not pull SDA low for the address acknowledge, nor for any later byte, until the next start.
- R2: After reset the registers hold: index 0 = 04h, index 1 = 00h, index 2 = C0h, index 3 = 08h, index 4 = 06h, index 5 = D8h.
- R3: Command byte bit 7 = 1 selects single-byte mode and bit 7 = 0 selects block mode. Bits 6:0 give the starting register index. The pointer is kept across a repeated start.
- R4: A single-byte write (start, D6h, command, data, stop) stores the data at the indexed register. The target acknowledges every byte.
- R5: A single-byte read (start, D6h, command, repeated start, D7h) returns the indexed register MSB first, which the host then NAKs.
- R6: A block write discards the first byte after the command (the length byte). It stores each later byte at ascending indices, starting at the command index.
- R7: A block read returns the contents of register index 4 first, then the registers from the command index in ascending order.
- R8: Register indices from 6 upward read as 00h, and writes to them change nothing.
- R9: `ref_en` = reg0 bit 2. `diff_en[0]` = reg2 bit 7. `diff_en[1]` = reg2 bit 6. `amp_custom` = reg5 bit 7. `amp_code` = reg5 bits 6:4.
- R10: A host NAK ends a read, and the target leaves SDA released. A stop returns the target to idle with SDA released. A transfer may end after any complete byte, and the next transfer then works normally.
- R11: The target changes `sda_oe` only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| ref_en | output | 1 | Reference output enable (reg0 bit 2) |
| diff_en | output | 2 | Differential output enables (reg2 bits 7 and 6) |
| amp_custom | output | 1 | Use programmed amplitude (reg5 bit 7) |
| amp_code | output | 3 | Amplitude code, 300 mV plus 100 mV per step (reg5 bits 6:4) |

## Verification
An SCL edge reaches the state machine three system clocks after it occurs at the pin: two synchroniser stages and one edge-compare stage. A register write therefore lands a few cycles after the SCL fall that ends the byte's eighth bit. The acknowledge or data bit on SDA is valid within four cycles of each SCL fall. The bench holds each SCL phase for twenty system clocks and samples SDA only in the middle of SCL high, well past that latency. The control outputs are compared only after the stop condition, by which time every write has settled.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_RX,
    S_ACK,
    S_TX,
    S_TXACK
  } i2cr_state_t;

  // Register positions that the chip-level outputs decode
  localparam int IDX_REF  = 0;
  localparam int IDX_DIFF = 2;
  localparam int IDX_CNT  = 4;
  localparam int IDX_AMP  = 5;

  // Power-on contents of each register index
  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h04;
      2:       return 8'hC0;
      3:       return 8'h08;
      4:       return 8'h06;
      5:       return 8'hD8;
      default: return 8'h00;
    endcase
  endfunction

  // Target address match on the upper seven bits of the address byte
  function automatic logic addr_hit(input logic [7:0] abyte, input logic [6:0] dev);
    return abyte[7:1] == dev;
  endfunction

endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int W = SYNC + 1;

  logic [W-1:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[W-2:0], scl_i};
      sda_q <= {sda_q[W-2:0], sda_i};
    end
  end

  logic scl_p, sda_p;
  assign scl_s = scl_q[SYNC-1];
  assign sda_s = sda_q[SYNC-1];
  assign scl_p = scl_q[SYNC];
  assign sda_p = sda_q[SYNC];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cr_regs.sv
module i2cr_regs #(
  parameter int NREG = 6,
  parameter int IW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic [IW-1:0]   wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [IW-1:0]   rd_idx,
  output logic [7:0]      rd_data,
  output logic [NREG*8-1:0] reg_flat
);
  import i2cr_pkg::*;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= reg_default(g);
      else if (wr_stb && wr_idx == IW'(g))
        q <= wr_data;
    end
    assign reg_flat[g*8 +: 8] = q;
  end

  // Unimplemented indices fall through to zero
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++)
      if (rd_idx == IW'(k)) rd_data = reg_flat[k*8 +: 8];
  end
endmodule

// File: rtl/i2cr_ctrl.sv
module i2cr_ctrl #(
  parameter int         NREG     = 6,
  parameter int         SYNC     = 2,
  parameter logic [6:0] DEV_ADDR = 7'h6B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       ref_en,
  output logic [1:0] diff_en,
  output logic       amp_custom,
  output logic [2:0] amp_code
);
  import i2cr_pkg::*;

  localparam int IW = 7;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cr_sync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cr_state_t st;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [IW-1:0] ptr;
  logic          rw, byte_mode, have_cmd, have_cnt, rd_first, host_nak;

  logic          wr_stb;
  logic [7:0]    rd_data;
  logic [NREG*8-1:0] reg_flat;

  // Named events for the checker
  logic byte_done, addr_done, addr_match;
  assign byte_done  = scl_fall && bitcnt == 4'd8;
  assign addr_done  = (st == S_ADDR) && byte_done;
  assign addr_match = addr_hit(shreg, DEV_ADDR);
  assign wr_stb     = (st == S_RX) && byte_done && have_cmd && (byte_mode || have_cnt);

  i2cr_regs #(.NREG(NREG), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_idx(ptr), .wr_data(shreg),
    .rd_idx(ptr), .rd_data(rd_data), .reg_flat(reg_flat)
  );

  logic send_cnt;
  assign send_cnt = rd_first && !byte_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      ptr       <= '0;
      rw        <= 1'b0;
      byte_mode <= 1'b0;
      have_cmd  <= 1'b0;
      have_cnt  <= 1'b0;
      rd_first  <= 1'b0;
      host_nak  <= 1'b0;
    end else if (start_det) begin
      st     <= S_ADDR;
      bitcnt <= '0;
    end else if (stop_det) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_ADDR, S_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            if (st == S_ADDR) begin
              if (addr_match) begin
                st       <= S_ACK;
                rw       <= shreg[0];
                rd_first <= 1'b1;
                if (!shreg[0]) begin
                  have_cmd <= 1'b0;
                  have_cnt <= 1'b0;
                end
              end else begin
                st <= S_IDLE;
              end
            end else begin
              st <= S_ACK;
              if (!have_cmd) begin
                ptr       <= shreg[6:0];
                byte_mode <= shreg[7];
                have_cmd  <= 1'b1;
              end else if (!byte_mode && !have_cnt) begin
                have_cnt <= 1'b1;
              end else begin
                ptr <= ptr + 7'd1;
              end
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              st       <= S_TX;
              rd_first <= 1'b0;
              if (send_cnt) shreg <= reg_flat[IDX_CNT*8 +: 8];
              else begin
                shreg <= rd_data;
                ptr   <= ptr + 7'd1;
              end
            end else begin
              st <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            shreg  <= {shreg[6:0], 1'b1};
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) st <= S_TXACK;
          end
        end
        S_TXACK: begin
          if (scl_rise) host_nak <= sda_s;
          else if (scl_fall) begin
            if (host_nak) st <= S_IDLE;
            else begin
              st     <= S_TX;
              bitcnt <= '0;
              shreg  <= rd_data;
              ptr    <= ptr + 7'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = (st == S_ACK) || (st == S_TX && !shreg[7]);

  assign ref_en     = reg_flat[IDX_REF*8 + 2];
  assign diff_en[0] = reg_flat[IDX_DIFF*8 + 7];
  assign diff_en[1] = reg_flat[IDX_DIFF*8 + 6];
  assign amp_custom = reg_flat[IDX_AMP*8 + 7];
  assign amp_code   = reg_flat[IDX_AMP*8 + 4 +: 3];
endmodule

// File: rtl/i2cr_chk.sv
module i2cr_chk #(
  parameter int NREG = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              stop_det,
  input logic              addr_done,
  input logic              addr_match,
  input logic              wr_stb,
  input logic [6:0]        wr_idx,
  input logic [NREG*8-1:0] reg_flat,
  input logic              ref_en,
  input logic [1:0]        diff_en,
  input logic              amp_custom,
  input logic [2:0]        amp_code
);
  // R11: SDA drive only moves while SCL is low
  p_drive_rise_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  p_drive_fall_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_s);

  // R1: foreign address gets no acknowledge
  p_no_ack_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_match) |=> !sda_oe);

  // R10: bus released after a stop
  p_release_on_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R8: writes past the bank leave every register alone
  p_oob_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_idx >= 7'(NREG)) |=> $stable(reg_flat));

  // R2, R9: outputs reflect power-on contents on leaving reset
  p_reset_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ref_en && diff_en == 2'b11 && amp_custom && amp_code == 3'b101));
endmodule

bind i2cr_ctrl i2cr_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .stop_det(stop_det), .addr_done(addr_done), .addr_match(addr_match),
  .wr_stb(wr_stb), .wr_idx(ptr), .reg_flat(reg_flat),
  .ref_en(ref_en), .diff_en(diff_en), .amp_custom(amp_custom), .amp_code(amp_code)
);

// File: tb/sim_i2cr_ctrl.sv
`timescale 1ns/1ps
module sim_i2cr_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe, ref_en, amp_custom;
  logic [1:0] diff_en;
  logic [2:0] amp_code;
  logic sda_bus;

  always #5 clk = ~clk;
  assign sda_bus = sda_h & ~sda_oe;

  i2cr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus), .sda_oe(sda_oe),
    .ref_en(ref_en), .diff_en(diff_en), .amp_custom(amp_custom), .amp_code(amp_code)
  );

  localparam int H = 20;
  int total = 0, fails = 0;
  bit done = 0;
  logic [7:0] rbuf [0:7];

  // {index, written value, expected readback}
  localparam logic [23:0] VEC [0:5] = '{
    {8'h00, 8'hFB, 8'hFB},
    {8'h02, 8'h40, 8'h40},
    {8'h03, 8'h5A, 8'h5A},
    {8'h05, 8'hB0, 8'hB0},
    {8'h06, 8'hFF, 8'h00},
    {8'h7F, 8'h12, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_h = 1; hw(H); scl_h = 1; hw(H); sda_h = 0; hw(H); scl_h = 0; hw(H);
  endtask

  task automatic bus_stop;
    sda_h = 0; hw(H); scl_h = 1; hw(H); sda_h = 1; hw(H);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; hw(H); scl_h = 1; hw(H); scl_h = 0;
    end
    sda_h = 1; hw(H); scl_h = 1; hw(H/2); ack = ~sda_bus; hw(H/2); scl_h = 0;
  endtask

  task automatic rd_byte(input logic nak, output logic [7:0] d);
    sda_h = 1;
    for (int i = 0; i < 8; i++) begin
      hw(H); scl_h = 1; hw(H/2); d = {d[6:0], sda_bus}; hw(H/2); scl_h = 0;
    end
    hw(4); sda_h = nak; hw(H); scl_h = 1; hw(H); scl_h = 0; hw(4); sda_h = 1;
  endtask

  task automatic byte_write(input logic [7:0] idx, input logic [7:0] d, input string req);
    logic a1, a2, a3;
    bus_start; wr_byte(8'hD6, a1); wr_byte({1'b1, idx[6:0]}, a2); wr_byte(d, a3); bus_stop;
    chk({req, " R4 acks"}, {a1, a2, a3}, 3'b111);
  endtask

  task automatic byte_read(input logic [7:0] idx, output logic [7:0] d);
    logic a;
    bus_start; wr_byte(8'hD6, a); wr_byte({1'b1, idx[6:0]}, a);
    bus_start; wr_byte(8'hD7, a); rd_byte(1'b1, d); bus_stop;
  endtask

  // n bytes read in total (count byte included), NAK on the last
  task automatic block_read(input logic [6:0] idx, input int n);
    logic a;
    logic [7:0] d;
    bus_start; wr_byte(8'hD6, a); wr_byte({1'b0, idx}, a);
    bus_start; wr_byte(8'hD7, a);
    for (int i = 0; i < n; i++) begin
      rd_byte(i == n - 1, d); rbuf[i] = d;
    end
    bus_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R10 watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic a1, a2, a3;
    hw(5); rst_n = 1; hw(5);

    // R2 / R9 reset state at the pins
    chk("R2 sda released", sda_oe, 0);
    chk("R9 ref_en default", ref_en, 1);
    chk("R9 diff_en default", diff_en, 2'b11);
    chk("R9 amp_custom default", amp_custom, 1);
    chk("R9 amp_code default", amp_code, 3'b101);

    // R7 / R2 block read of every default, count byte first
    block_read(7'd0, 7);
    chk("R7 count byte", rbuf[0], 8'h06);
    chk("R2 reg0", rbuf[1], 8'h04);
    chk("R2 reg1", rbuf[2], 8'h00);
    chk("R2 reg2", rbuf[3], 8'hC0);
    chk("R2 reg3", rbuf[4], 8'h08);
    chk("R2 reg4", rbuf[5], 8'h06);
    chk("R2 reg5", rbuf[6], 8'hD8);
    chk("R10 released after read", sda_oe, 0);

    // R4 / R5 / R8 vector walk: byte write then byte read
    for (int v = 0; v < 6; v++) begin
      byte_write(VEC[v][23:16], VEC[v][15:8], "R4");
      byte_read(VEC[v][23:16], d);
      chk((VEC[v][23:16] >= 8'd6) ? "R8 out-of-range readback" : "R5 readback", d, VEC[v][7:0]);
    end
    chk("R9 ref_en from reg0 bit2", ref_en, 0);
    chk("R9 diff_en from reg2 bits7/6", diff_en, 2'b10);
    chk("R9 amp_custom from reg5 bit7", amp_custom, 1);
    chk("R9 amp_code from reg5 bits6:4", amp_code, 3'b011);

    // R1 foreign address: no ack, following bytes ignored
    bus_start; wr_byte(8'hD4, a1); wr_byte(8'h83, a2); wr_byte(8'h00, a3); bus_stop;
    chk("R1 foreign address nak", {a1, a2, a3}, 3'b000);
    byte_read(8'd3, d);
    chk("R1 foreign write ignored", d, 8'h5A);

    // R6 block write: length byte dropped, data from index 0 upward
    bus_start; wr_byte(8'hD6, a1); wr_byte(8'h00, a2); wr_byte(8'h03, a3);
    chk("R6 header acks", {a1, a2, a3}, 3'b111);
    wr_byte(8'h04, a1); wr_byte(8'h11, a2); wr_byte(8'hC0, a3); bus_stop;
    chk("R6 data acks", {a1, a2, a3}, 3'b111);
    chk("R6 ref_en after block write", ref_en, 1);
    chk("R6 diff_en after block write", diff_en, 2'b11);

    // R7 / R3 / R10 block read from index 1, ended early
    block_read(7'd1, 3);
    chk("R7 count byte again", rbuf[0], 8'h06);
    chk("R3 block start index", rbuf[1], 8'h11);
    chk("R7 ascending", rbuf[2], 8'hC0);

    // R8 block write running past the last register
    bus_start; wr_byte(8'hD6, a1); wr_byte(8'h05, a1); wr_byte(8'h02, a1);
    wr_byte(8'h00, a1); wr_byte(8'h77, a2); bus_stop;
    chk("R8 acks past end", {a1, a2}, 2'b11);
    chk("R8 amp_custom cleared", amp_custom, 0);
    chk("R8 amp_code cleared", amp_code, 3'b000);
    byte_read(8'd6, d);
    chk("R8 index 6 reads zero", d, 8'h00);

    // R10 transfer cut after the command byte, then a normal one
    bus_start; wr_byte(8'hD6, a1); wr_byte(8'h82, a1); bus_stop;
    byte_read(8'd2, d);
    chk("R10 recovery after short transfer", d, 8'hC0);

    // R3 pointer kept across repeated start, single-byte mode
    byte_read(8'd4, d);
    chk("R3 byte mode index 4", d, 8'h06);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule